// File: doc/BRIEF.md
# DDR Write-Burst Read-Interrupt Sequencer

This block sits on the controller side of a mobile DDR SDRAM interface. A client presents write and read requests on a single-entry command port. The sequencer turns each request into one memory command per clock: NOP, WRITE or READ. It drives the write data and data-mask lanes, and it owns the output-enable of the DQ and DQS pins. Each clock carries two data slots, modelling the double data rate. Slot 0 is the low half of every data word and slot 1 the high half.

A write burst is eight beats over four clocks. A read may arrive while that burst is still running, and it then cuts the burst short instead of waiting for it to end. The sequencer leaves every beat that was driven before the hand-over unmasked, so those beats are really written. It masks the beats on the clock just before the READ and every beat from the READ onward. It turns the bus around and stops toggling DQS on masked beats. The READ is placed so that a WRITE is never followed by a READ on the very next clock, and so that a masked or idle clock separates the last written beat from the READ. Read data is taken CAS latency (3) clocks after the READ, two beats per clock, for eight beats.

Top module: `ddr_wr_rd_interrupt`

## Requirements
- R1: A write request accepted at a rising edge puts WRITE (code 01) on `mem_cmd` in the clock that follows. During the next four clocks, `wdata_pull` is high and `dq_out` equals `wr_pair`, with the low half as the even beat. While the bus is still owned by the controller in those clocks, `dq_oe` is also high.
- R2: A write burst that no read interrupts drives `dm_out` = 00 on all four of its data clocks.
- R3: READ (code 10) never appears on the clock right after WRITE. A read accepted in the clock right after WRITE is issued two clocks after the WRITE.
- R4: Beats on data clocks earlier than the clock just before the interrupting READ carry `dm_out` = 00.
- R5: On the data clock just before the interrupting READ, and on every remaining data clock of that burst from the READ onward, `dm_out` = 11.
- R6: `dq_oe` and `dqs_oe` are low from the READ clock through the last read-data clock. This covers at least the one clock before read data arrives.
- R7: If the clock in which a read is accepted carries WRITE or an unmasked beat, the READ follows one clock later, after a hold clock. Otherwise the READ goes out in the clock of acceptance.
- R8: `dqs_run` is high exactly on data clocks that the controller drives with unmasked beats.
- R9: `rd_valid` = 11 and `rd_data` = `dq_in` on the four clocks starting 3 clocks after READ. `rd_valid` is 00 at all other times.
- R10: `req_ready` is high for a read when no read is pending or returning data. For a write, it is high only when, in addition, no write command or write data clock is pending.
- R11: While reset is held, `mem_cmd` is NOP (00), the bus enables, `dm_out` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_rd | input | 1 | 1 = read request, 0 = write request |
| req_ready | output | 1 | Request is accepted at this edge if valid |
| wr_pair | input | 2*DATA_W | Two write beats for the current data clock |
| wdata_pull | output | 1 | Current clock is a write data clock |
| mem_cmd | output | 2 | Memory command: 00 NOP, 01 WRITE, 10 READ |
| dq_out | output | 2*DATA_W | Write beats driven toward DQ |
| dq_oe | output | 1 | DQ output enable |
| dqs_oe | output | 1 | DQS output enable |
| dqs_run | output | 1 | Toggle DQS this clock |
| dm_out | output | 2 | Data mask per slot, 1 = masked |
| dq_in | input | 2*DATA_W | Beats returned from DQ |
| rd_valid | output | 2 | Captured read beat per slot |
| rd_data | output | 2*DATA_W | Captured read beats |

## Verification
The bench sweeps the read's acceptance point from the WRITE clock itself to two clocks past the burst. Across that sweep it covers the forbidden one-clock spacing, hold clocks landing on a data clock and on an idle clock, and a read needing no hold. A sequencer that ignored the spacing rule would show READ right after WRITE. One with the mask boundary off by a clock would either mask a beat that must be written or leave the beat before the READ unmasked. Releasing the bus late would show `dq_oe` high in the READ clock. A miscounted CAS latency shifts every `rd_valid` clock and is caught by the per-clock expectation table.

// File: rtl/ddr_wri_pkg.sv
package ddr_wri_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10
  } mem_cmd_e;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_HOLD,
    RS_CMD,
    RS_DATA
  } rd_state_e;

  // clocks needed to move one burst at two beats per clock
  function automatic int data_clocks(input int burst_len);
    return burst_len / 2;
  endfunction

  // count value (clocks after READ) of the final read-data clock
  function automatic int rd_last_tick(input int cas_lat, input int burst_len);
    return cas_lat + burst_len / 2 - 1;
  endfunction

  // per-slot mask word
  function automatic logic [1:0] slot_mask(input logic masked);
    return {masked, masked};
  endfunction

endpackage

// File: rtl/wri_write_engine.sv
module wri_write_engine
  import ddr_wri_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int DATA_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_start,
  input  logic                rd_start,
  input  logic                rd_owns_bus,
  input  logic [2*DATA_W-1:0] wr_pair,
  output logic                wcmd,
  output logic                data_act,
  output logic                bus_hot,
  output logic                wr_busy,
  output logic [2*DATA_W-1:0] dq_out,
  output logic                dq_oe,
  output logic [1:0]          dm_out,
  output logic                dqs_run
);

  localparam int DCLK = data_clocks(BURST_LEN);
  localparam int CW   = $clog2(DCLK + 1);
  localparam logic [CW-1:0] DCLK_V = CW'(DCLK);

  logic          wcmd_q;
  logic [CW-1:0] left_q;
  logic          mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcmd_q <= 1'b0;
      left_q <= '0;
      mask_q <= 1'b0;
    end else begin
      wcmd_q <= wr_start;
      if (wcmd_q)
        left_q <= DCLK_V;
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
      if (wr_start)
        mask_q <= 1'b0;
      else if (rd_start)
        mask_q <= 1'b1;
    end
  end

  assign wcmd     = wcmd_q;
  assign data_act = (left_q != '0);
  assign wr_busy  = wcmd_q | data_act;
  assign bus_hot  = wcmd_q | (data_act & ~mask_q);
  assign dq_oe    = data_act & ~rd_owns_bus;
  assign dm_out   = data_act ? slot_mask(mask_q) : 2'b00;
  assign dqs_run  = data_act & ~mask_q;
  assign dq_out   = dq_oe ? wr_pair : '0;

  // R1: data clocks start right after the WRITE clock
  assert_burst_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wcmd_q |=> data_act);

  // R8: DQS toggles only while the controller still owns the bus
  assert_dqs_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_run |-> !rd_owns_bus);

endmodule

// File: rtl/wri_read_ctrl.sv
module wri_read_ctrl
  import ddr_wri_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int CAS_LAT   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_start,
  input  logic       bus_hot,
  output logic       rd_busy,
  output logic       rd_cmd,
  output logic       rd_owns_bus,
  output logic [1:0] rd_valid
);

  localparam int LAST = rd_last_tick(CAS_LAT, BURST_LEN);
  localparam int CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] LAST_V = CW'(LAST);
  localparam logic [CW-1:0] CL_V   = CW'(CAS_LAT);

  rd_state_e     state_q;
  logic [CW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      tick_q  <= '0;
    end else begin
      unique case (state_q)
        RS_IDLE: if (rd_start) state_q <= bus_hot ? RS_HOLD : RS_CMD;
        RS_HOLD: state_q <= RS_CMD;
        RS_CMD: begin
          state_q <= RS_DATA;
          tick_q  <= CW'(1);
        end
        RS_DATA: begin
          if (tick_q == LAST_V) begin
            state_q <= RS_IDLE;
            tick_q  <= '0;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign rd_busy     = (state_q != RS_IDLE);
  assign rd_cmd      = (state_q == RS_CMD);
  assign rd_owns_bus = (state_q == RS_CMD) | (state_q == RS_DATA);
  assign rd_valid    = ((state_q == RS_DATA) && (tick_q >= CL_V)) ? 2'b11 : 2'b00;

  // R7: a hold clock is always followed by the READ
  assert_hold_then_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_HOLD) |=> rd_cmd);

  // R9: read data never shows up in the READ clock itself
  assert_no_data_at_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |-> (rd_valid == 2'b00));

endmodule

// File: rtl/ddr_wr_rd_interrupt.sv
module ddr_wr_rd_interrupt
  import ddr_wri_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int CAS_LAT   = 3,
  parameter int DATA_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_rd,
  output logic                req_ready,
  input  logic [2*DATA_W-1:0] wr_pair,
  output logic                wdata_pull,
  output logic [1:0]          mem_cmd,
  output logic [2*DATA_W-1:0] dq_out,
  output logic                dq_oe,
  output logic                dqs_oe,
  output logic                dqs_run,
  output logic [1:0]          dm_out,
  input  logic [2*DATA_W-1:0] dq_in,
  output logic [1:0]          rd_valid,
  output logic [2*DATA_W-1:0] rd_data
);

  logic accept, wr_start, rd_start;
  logic wcmd, data_act, bus_hot, wr_busy;
  logic rd_busy, rd_cmd, rd_owns_bus;

  assign req_ready = req_rd ? ~rd_busy : (~rd_busy & ~wr_busy);
  assign accept    = req_valid & req_ready;
  assign wr_start  = accept & ~req_rd;
  assign rd_start  = accept & req_rd;

  wri_write_engine #(.BURST_LEN(BURST_LEN), .DATA_W(DATA_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_start    (wr_start),
    .rd_start    (rd_start),
    .rd_owns_bus (rd_owns_bus),
    .wr_pair     (wr_pair),
    .wcmd        (wcmd),
    .data_act    (data_act),
    .bus_hot     (bus_hot),
    .wr_busy     (wr_busy),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .dm_out      (dm_out),
    .dqs_run     (dqs_run)
  );

  wri_read_ctrl #(.BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_start    (rd_start),
    .bus_hot     (bus_hot),
    .rd_busy     (rd_busy),
    .rd_cmd      (rd_cmd),
    .rd_owns_bus (rd_owns_bus),
    .rd_valid    (rd_valid)
  );

  assign mem_cmd    = wcmd ? CMD_WRITE : (rd_cmd ? CMD_READ : CMD_NOP);
  assign dqs_oe     = dq_oe;
  assign wdata_pull = data_act;
  assign rd_data    = (rd_valid != 2'b00) ? dq_in : '0;

  // R3: WRITE is never followed by READ on the next clock
  assert_no_read_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_WRITE) |=> (mem_cmd != CMD_READ));

  // R7: an unmasked beat is never directly followed by READ
  assert_gap_before_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && dm_out == 2'b00) |=> (mem_cmd != CMD_READ));

  // R6: bus released in the READ clock and the clock after it
  assert_bus_free_at_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_READ) |-> (!dq_oe && !dqs_oe));
  assert_bus_free_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_READ) |=> !dq_oe);
  assert_bus_free_on_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid != 2'b00) |-> !dq_oe);

  // R5: remaining beats at the READ clock are masked
  assert_mask_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_READ && data_act) |-> (dm_out == 2'b11));

endmodule

// File: tb/ddr_wr_rd_interrupt_test.sv
module ddr_wr_rd_interrupt_test;

  localparam int DW   = 16;
  localparam int MAXC = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_rd = 1'b0;
  logic          req_ready;
  logic [2*DW-1:0] wr_pair = '0;
  logic          wdata_pull;
  logic [1:0]    mem_cmd;
  logic [2*DW-1:0] dq_out;
  logic          dq_oe, dqs_oe, dqs_run;
  logic [1:0]    dm_out;
  logic [2*DW-1:0] dq_in = '0;
  logic [1:0]    rd_valid;
  logic [2*DW-1:0] rd_data;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [1:0] e_cmd [MAXC];
  logic       e_oe  [MAXC];
  logic [1:0] e_dm  [MAXC];
  logic       e_dqs [MAXC];
  logic       e_pull[MAXC];
  logic       e_rv  [MAXC];
  int         rd_q[$];

  ddr_wr_rd_interrupt #(.BURST_LEN(8), .CAS_LAT(3), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_ready(req_ready), .wr_pair(wr_pair), .wdata_pull(wdata_pull),
    .mem_cmd(mem_cmd), .dq_out(dq_out), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
    .dqs_run(dqs_run), .dm_out(dm_out), .dq_in(dq_in), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2*DW-1:0] wpat(input int c);
    return {DW'(c * 3 + 1), DW'(c ^ 16'h5a5a)};
  endfunction
  function automatic logic [2*DW-1:0] rpat(input int c);
    return {DW'(c + 16'h0100), DW'(~c)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // monitor: compare every clock against the scoreboard
  initial begin
    for (int i = 0; i < MAXC; i++) begin
      e_cmd[i] = 2'b00; e_oe[i] = 1'b0; e_dm[i] = 2'b00;
      e_dqs[i] = 1'b0; e_pull[i] = 1'b0; e_rv[i] = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (cyc < MAXC) begin
        check("R1 R3 mem_cmd", mem_cmd, e_cmd[cyc]);
        check("R6 dq_oe", dq_oe, e_oe[cyc]);
        check("R6 dqs_oe", dqs_oe, e_oe[cyc]);
        check("R5 dm_out", dm_out, e_dm[cyc]);
        check("R8 dqs_run", dqs_run, e_dqs[cyc]);
        check("R1 wdata_pull", wdata_pull, e_pull[cyc]);
        check("R9 rd_valid", rd_valid, e_rv[cyc] ? 2'b11 : 2'b00);
        if (e_oe[cyc]) check("R1 dq_out", dq_out, wpat(cyc));
        if (e_rv[cyc]) check("R9 rd_data", rd_data, rpat(cyc));
        if (mem_cmd == 2'b10) begin
          if (rd_q.size() == 0) check("R3 unexpected READ", 1, 0);
          else check("R3 READ clock", cyc, rd_q.pop_front());
        end
      end
      #1;
      wr_pair = wpat(cyc + 1);
      dq_in   = rpat(cyc + 1);
    end
  end

  task automatic issue(input bit rd, output int acc);
    @(negedge clk);
    #2;
    req_rd = rd;
    req_valid = 1'b1;
    #1;
    check("R10 req_ready when free", req_ready, 1);
    acc = cyc + 1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic probe(input bit rd, input bit exp);
    @(negedge clk);
    #2;
    req_rd = rd;
    req_valid = 1'b1;
    #1;
    check("R10 req_ready while busy", req_ready, exp);
    req_valid = 1'b0;
  endtask

  task automatic expect_write(input int w);
    e_cmd[w] = 2'b01;
    for (int d = w + 1; d <= w + 4; d++) begin
      e_oe[d] = 1'b1; e_dm[d] = 2'b00; e_dqs[d] = 1'b1; e_pull[d] = 1'b1;
    end
  endtask

  task automatic expect_read(input int r);
    bit hot;
    int rc;
    hot = (e_cmd[r-1] == 2'b01) || (e_oe[r-1] && e_dm[r-1] == 2'b00);
    rc = hot ? r + 1 : r;          // R7 hold clock
    e_cmd[rc] = 2'b10;
    rd_q.push_back(rc);
    for (int d = rc - 1; d <= rc + 4; d++) begin
      if (e_pull[d]) begin          // R5 mask, R8 no DQS
        e_dm[d] = 2'b11;
        e_dqs[d] = 1'b0;
      end
      if (d >= rc) e_oe[d] = 1'b0;  // R6
    end
    for (int d = rc + 3; d <= rc + 6; d++) e_rv[d] = 1'b1;
  endtask

  initial begin
    int w, r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 mem_cmd", mem_cmd, 2'b00);
    check("R11 dq_oe", dq_oe, 0);
    check("R11 dm_out", dm_out, 2'b00);
    check("R11 rd_valid", rd_valid, 2'b00);
    check("R11 req_ready", req_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2: full burst, no interruption, then a read needing no hold (R7)
    issue(0, w);
    expect_write(w);
    probe(0, 0);                    // R10 write refused during burst
    repeat (8) @(posedge clk);
    issue(1, r);
    expect_read(r);
    probe(1, 0);                    // R10 read refused while reading
    probe(0, 0);
    repeat (12) @(posedge clk);

    // R3 R4 R5: sweep where the read lands relative to the WRITE
    for (int n = 0; n <= 5; n++) begin
      issue(0, w);
      expect_write(w);
      repeat (n) @(posedge clk);
      issue(1, r);
      expect_read(r);
      repeat (14) @(posedge clk);
    end

    check("R3 all READs seen", rd_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule